// File: doc/BRIEF.md
# Video Timing Flag Extractor

This block watches a parallel stream of 10-bit video words, one per pixel clock, and derives horizontal and vertical blanking flags from the timing reference sequences embedded in the stream. A timing reference sequence is a three-word preamble (all ones, all zeros, all zeros) followed by an ID word. The ID word says whether the sequence opens blanking (end of active video) or closes it (start of active video), and whether the line belongs to the vertical blanking interval. The words pass through an internal delay line so that the flags change on the same output clock as the words they describe.

A static select input picks one of two horizontal flag shapes. In the first, the flag covers the whole blanking gap, including all four words of both reference sequences. In the second, the flag follows only the H bit carried in the ID words. A carrier-detect input, which arrives from outside the pixel clock domain and is synchronised inside, marks the input as invalid. While it is asserted the data output is forced to zero, both flags are held low and the lock indicator drops. The lock indicator rises once the stream shows a repeating line length.

Top module: `video_flag_extract`

## Requirements
- R1: With the carrier present, `dout` equals the `din` word presented exactly four clock edges earlier.
- R2: A reference sequence is recognised only when an ID word follows the words 3FF, 000, 000 on consecutive clocks. ID bit 6 is the H bit (1 marks end of active video, 0 marks start of active video) and bit 7 is the V bit. Any other ordering changes neither flag.
- R3: With `h_mode` = 0, `h_flag` is high from the output clock that carries the 3FF word of an end-of-active sequence through the output clock that carries the ID word of the following start-of-active sequence. It is low on all other clocks.
- R4: With `h_mode` = 1, `h_flag` takes the H bit of each ID word on the output clock that carries that ID word, and holds it until the next ID word.
- R5: `v_flag` takes the V bit of each ID word (both kinds) on the output clock that carries that ID word, and holds it until the next ID word.
- R6: `carrier_lost` passes through a two-stage synchroniser. Two clock edges after it rises, `dout` reads zero and `h_flag`, `v_flag` and `locked` read low. Two edges after it falls, normal output resumes.
- R7: `locked` rises on the clock after an end-of-active ID word is taken in, when the spacing from the previous such ID word equals the spacing before that. Three end-of-active sequences are therefore needed with the carrier present.
- R8: `locked` falls on the clock after an end-of-active ID word whose spacing differs from the previous one. It also drops while the carrier is lost. After the carrier returns, three fresh end-of-active sequences are needed again.
- R9: A synchronous active-high `rst` clears the delay line, both flags and `locked`, so the outputs read zero on the clock after reset is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_lost | input | 1 | High when the input signal is invalid; asynchronous to clk |
| h_mode | input | 1 | Horizontal flag shape: 0 full blanking gap, 1 ID-bit based |
| din | input | DATA_W | Incoming video word |
| dout | output | DATA_W | Delayed video word, zero while muted |
| h_flag | output | 1 | Horizontal blanking flag |
| v_flag | output | 1 | Vertical blanking flag |
| locked | output | 1 | Stream shows a stable line length |

## Verification
The bench drives whole lines in both H modes, so each flag edge is checked against the exact word on `dout`. A flag computed one stage early or late would disagree with the 3FF word or the ID word it is supposed to share a clock with. A near-miss preamble (3FF, 000, then a non-zero word) is followed by a plausible ID word. A detector that does not insist on three consecutive preamble words would raise `h_flag` or `v_flag` at that point. Carrier loss is applied in the middle of blanking with V set, and the bench checks the exact clock on which muting starts and ends, so a missing or extra synchroniser stage shows up. The lock tests stretch one line by two words and rely on a stale spacing left over from the table run. A design that compared against the wrong earlier interval, or that kept its count across carrier loss, would report `locked` on the wrong line.

// File: rtl/vfx_pkg.sv
package vfx_pkg;

    // Latency of the word path; the preamble detector taps stages 0..2
    localparam int PIPE_DEPTH = 4;

    // Bit positions inside the ID word
    localparam int H_POS = 6;
    localparam int V_POS = 7;

    typedef enum logic {
        HSPAN_BLANK = 1'b0,
        HSPAN_ID    = 1'b1
    } hspan_e;

    // Marker carried alongside each word in the delay line
    typedef struct packed {
        logic id;   // this word is a reference ID word
        logic v;    // decoded V bit
        logic h;    // decoded H bit
    } trs_tag_t;

    function automatic logic eav_mark(trs_tag_t t);
        return t.id & t.h;
    endfunction

    function automatic logic sav_mark(trs_tag_t t);
        return t.id & ~t.h;
    endfunction

endpackage

// File: rtl/vfx_trs_detect.sv
module vfx_trs_detect
    import vfx_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              h_bit,
    input  logic              v_bit,
    input  logic [DATA_W-1:0] w_m1,
    input  logic [DATA_W-1:0] w_m2,
    input  logic [DATA_W-1:0] w_m3,
    output trs_tag_t          tag
);

    logic preamble_hit;

    // Oldest word all ones, then two words of all zeros
    assign preamble_hit = (&w_m3) & ~(|w_m2) & ~(|w_m1);

    always_comb begin
        tag = '0;
        if (preamble_hit) begin
            tag.id = 1'b1;
            tag.h  = h_bit;
            tag.v  = v_bit;
        end
    end

endmodule

// File: rtl/vfx_delay_line.sv
module vfx_delay_line
    import vfx_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DATA_W-1:0]            in_word,
    input  trs_tag_t                     in_tag,
    output logic [DEPTH-1:0][DATA_W-1:0] tap_word,
    output trs_tag_t                     tag_pre,
    output logic                         sav_at_out
);

    localparam int TAG_STAGES = DEPTH - 1;

    trs_tag_t [TAG_STAGES-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_word   <= '0;
            tag_q      <= '0;
            sav_at_out <= 1'b0;
        end else begin
            tap_word   <= {tap_word[DEPTH-2:0], in_word};
            tag_q      <= {tag_q[TAG_STAGES-2:0], in_tag};
            sav_at_out <= sav_mark(tag_q[TAG_STAGES-1]);
        end
    end

    assign tag_pre = tag_q[TAG_STAGES-1];

endmodule

// File: rtl/vfx_flag_gen.sv
module vfx_flag_gen
    import vfx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     eav_in,
    input  trs_tag_t tag_pre,
    input  logic     sav_out,
    output logic     h_blank,
    output logic     h_id,
    output logic     v_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_blank <= 1'b0;
            h_id    <= 1'b0;
            v_q     <= 1'b0;
        end else begin
            // Full-gap shape: open as the preamble reaches the output,
            // close once the start-of-active ID word has left it
            if (eav_in) begin
                h_blank <= 1'b1;
            end else if (sav_out) begin
                h_blank <= 1'b0;
            end
            // ID-bit shape and V: load as the ID word enters the output
            if (tag_pre.id) begin
                h_id <= tag_pre.h;
                v_q  <= tag_pre.v;
            end
        end
    end

endmodule

// File: rtl/vfx_lock_mon.sv
module vfx_lock_mon #(
    parameter int LEN_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic eav_in,
    input  logic loss,
    output logic lock_q
);

    logic [LEN_W-1:0] span_cnt;
    logic [LEN_W-1:0] span_prev;
    logic [1:0]       eav_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            span_cnt  <= '0;
            span_prev <= '0;
            eav_seen  <= '0;
            lock_q    <= 1'b0;
        end else begin
            if (span_cnt != '1) begin
                span_cnt <= span_cnt + 1'b1;
            end
            if (eav_in) begin
                span_cnt <= {{(LEN_W-1){1'b0}}, 1'b1};
                if (eav_seen != 2'd0) begin
                    span_prev <= span_cnt;
                end
                if (eav_seen == 2'd2) begin
                    lock_q <= (span_cnt == span_prev);
                end else begin
                    eav_seen <= eav_seen + 2'd1;
                end
            end
            if (loss) begin
                eav_seen <= '0;
                lock_q   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/video_flag_extract.sv
module video_flag_extract
    import vfx_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              carrier_lost,
    input  logic              h_mode,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              h_flag,
    output logic              v_flag,
    output logic              locked
);

    localparam int DEPTH   = PIPE_DEPTH;
    localparam int TAP_OUT = DEPTH - 1;

    logic [SYNC_STAGES-1:0]       cd_sync;
    logic                         cd_s;
    logic [DEPTH-1:0][DATA_W-1:0] tap_word;
    trs_tag_t                     new_tag;
    trs_tag_t                     tag_pre;
    logic                         sav_out;
    logic                         eav_in;
    logic                         h_blank;
    logic                         h_id;
    logic                         v_q;
    logic                         lock_q;
    logic                         h_sel;
    hspan_e                       mode_sel;

    // Carrier-detect crosses into the pixel clock domain
    generate
        if (SYNC_STAGES < 2) begin : g_sync_one
            always_ff @(posedge clk) begin
                if (rst) cd_sync <= '0;
                else     cd_sync <= carrier_lost;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk) begin
                if (rst) cd_sync <= '0;
                else     cd_sync <= {cd_sync[SYNC_STAGES-2:0], carrier_lost};
            end
        end
    endgenerate

    assign cd_s = cd_sync[SYNC_STAGES-1];

    vfx_trs_detect #(.DATA_W(DATA_W)) u_detect (
        .h_bit (din[H_POS]),
        .v_bit (din[V_POS]),
        .w_m1  (tap_word[0]),
        .w_m2  (tap_word[1]),
        .w_m3  (tap_word[2]),
        .tag   (new_tag)
    );

    vfx_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_delay (
        .clk        (clk),
        .rst        (rst),
        .in_word    (din),
        .in_tag     (new_tag),
        .tap_word   (tap_word),
        .tag_pre    (tag_pre),
        .sav_at_out (sav_out)
    );

    assign eav_in = eav_mark(new_tag);

    vfx_flag_gen u_flags (
        .clk     (clk),
        .rst     (rst),
        .eav_in  (eav_in),
        .tag_pre (tag_pre),
        .sav_out (sav_out),
        .h_blank (h_blank),
        .h_id    (h_id),
        .v_q     (v_q)
    );

    vfx_lock_mon #(.LEN_W(LEN_W)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .eav_in (eav_in),
        .loss   (cd_s),
        .lock_q (lock_q)
    );

    assign mode_sel = hspan_e'(h_mode);
    assign h_sel    = (mode_sel == HSPAN_ID) ? h_id : h_blank;

    assign dout   = cd_s ? '0 : tap_word[TAP_OUT];
    assign h_flag = h_sel  & ~cd_s;
    assign v_flag = v_q    & ~cd_s;
    assign locked = lock_q & ~cd_s;

endmodule

// File: rtl/video_flag_extract_chk.sv
module video_flag_extract_chk
    import vfx_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              carrier_lost,
    input logic              h_mode,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              h_flag,
    input logic              v_flag,
    input logic              locked
);

    AST_DATA_DELAY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) && !$past(rst, 4) && !$past(carrier_lost, 2))
        |-> (dout == $past(din, 4)));  // R1

    AST_MUTE_ALL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2) && $past(carrier_lost, 2))
        |-> (dout == '0 && !h_flag && !v_flag && !locked));  // R6

    AST_HBLANK_OPENS_ON_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        (!h_mode && !$past(h_mode) && !$past(rst) && !$past(carrier_lost, 2) && !$past(carrier_lost, 3)
         && $rose(h_flag))
        |-> (&dout));  // R3

    AST_HID_EDGE_ON_ID: assert property (@(posedge clk) disable iff (rst)
        (h_mode && $past(h_mode) && !$past(rst) && !$past(carrier_lost, 2) && !$past(carrier_lost, 3)
         && (h_flag != $past(h_flag)))
        |-> (dout[H_POS] == h_flag));  // R4

    AST_V_EDGE_ON_ID: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(carrier_lost, 2) && !$past(carrier_lost, 3) && (v_flag != $past(v_flag)))
        |-> (dout[V_POS] == v_flag));  // R5

    AST_LOCK_AFTER_EAV: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(locked))
        |-> ($past(din[H_POS]) && $past(din, 2) == '0 && $past(din, 3) == '0 && (&$past(din, 4))));  // R7

endmodule

bind video_flag_extract video_flag_extract_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .carrier_lost (carrier_lost),
    .h_mode       (h_mode),
    .din          (din),
    .dout         (dout),
    .h_flag       (h_flag),
    .v_flag       (v_flag),
    .locked       (locked)
);

// File: tb/video_flag_extract_tb.sv
`timescale 1ns/1ps
module video_flag_extract_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       carrier_lost;
    logic       h_mode;
    logic [9:0] din;
    logic [9:0] dout;
    logic       h_flag;
    logic       v_flag;
    logic       locked;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    video_flag_extract u_dut (
        .clk          (clk),
        .rst          (rst),
        .carrier_lost (carrier_lost),
        .h_mode       (h_mode),
        .din          (din),
        .dout         (dout),
        .h_flag       (h_flag),
        .v_flag       (v_flag),
        .locked       (locked)
    );

    // {word, expected h in full-gap mode, expected h in ID mode, expected v}
    // expectations apply when that word is on dout
    localparam logic [12:0] VEC [48] = '{
        {10'h3FF,3'b100},{10'h000,3'b100},{10'h000,3'b100},{10'h2C0,3'b111},
        {10'h104,3'b111},{10'h104,3'b111},{10'h3FF,3'b111},{10'h000,3'b111},
        {10'h000,3'b111},{10'h280,3'b101},{10'h155,3'b001},{10'h155,3'b001},
        {10'h3FF,3'b101},{10'h000,3'b101},{10'h000,3'b101},{10'h2C0,3'b111},
        {10'h104,3'b111},{10'h104,3'b111},{10'h3FF,3'b111},{10'h000,3'b111},
        {10'h000,3'b111},{10'h280,3'b101},{10'h155,3'b001},{10'h155,3'b001},
        {10'h3FF,3'b101},{10'h000,3'b101},{10'h000,3'b101},{10'h240,3'b110},
        {10'h104,3'b110},{10'h104,3'b110},{10'h3FF,3'b110},{10'h000,3'b110},
        {10'h000,3'b110},{10'h200,3'b100},{10'h155,3'b000},{10'h155,3'b000},
        {10'h3FF,3'b100},{10'h000,3'b100},{10'h000,3'b100},{10'h240,3'b110},
        {10'h104,3'b110},{10'h104,3'b110},{10'h3FF,3'b110},{10'h000,3'b110},
        {10'h000,3'b110},{10'h200,3'b100},{10'h155,3'b000},{10'h155,3'b000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input logic [9:0] w);
        @(negedge clk);
        din = w;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [9:0] line_word(input int i, input bit vb);
        case (i)
            0, 6:    return 10'h3FF;
            1, 2, 7, 8: return 10'h000;
            3:       return vb ? 10'h2C0 : 10'h240;
            4, 5:    return 10'h104;
            9:       return vb ? 10'h280 : 10'h200;
            default: return 10'h155;
        endcase
    endfunction

    // exp_lock < 0 means no lock check on this line
    task automatic send_line(input bit vb, input int extra, input int exp_lock, input string req);
        for (int i = 0; i < 12 + extra; i++) begin
            tick(line_word(i, vb));
            if (i == 3 && exp_lock >= 0) chk(req, locked, exp_lock[0]);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        carrier_lost = 1'b0;
        h_mode = 1'b0;
        din = 10'h3FF;
        repeat (6) @(posedge clk);
        #1;
        // R9: reset state
        chk("R9 dout", dout, 0);
        chk("R9 h", h_flag, 0);
        chk("R9 v", v_flag, 0);
        chk("R9 locked", locked, 0);
        @(negedge clk);
        rst = 1'b0;

        // Table walk: pass one in full-gap mode, pass two in ID mode
        for (int k = 0; k < 99; k++) begin
            h_mode = (k >= 51);
            tick((k < 96) ? VEC[k % 48][12:3] : 10'h155);
            if (k >= 3) begin
                int e;
                logic [12:0] ent;
                e = k - 3;
                ent = VEC[e % 48];
                chk("R1 dout", dout, ent[12:3]);
                if (h_mode) chk("R4 h_flag", h_flag, ent[1]);
                else        chk("R3 h_flag", h_flag, ent[2]);
                chk("R5 v_flag", v_flag, ent[0]);
                chk("R7 locked", locked, (e >= 24));
            end
        end

        // Spacing 15 after the flush words, then 12, 12
        h_mode = 1'b0;
        send_line(1'b0, 0, 0, "R8 spacing change");
        send_line(1'b0, 0, 0, "R8 one equal span");
        send_line(1'b0, 0, 1, "R7 relock");
        send_line(1'b0, 2, 1, "R7 still locked");
        send_line(1'b0, 0, 0, "R8 long line");
        send_line(1'b0, 0, 0, "R8 one equal span");
        send_line(1'b0, 0, 1, "R7 relock");

        // R2: broken preamble followed by an ID-like word is ignored
        h_mode = 1'b1;
        repeat (4) tick(10'h155);
        chk("R2 h before", h_flag, 0);
        tick(10'h3FF); chk("R2 h", h_flag, 0); chk("R2 v", v_flag, 0);
        tick(10'h000); chk("R2 h", h_flag, 0); chk("R2 v", v_flag, 0);
        tick(10'h155); chk("R2 h", h_flag, 0); chk("R2 v", v_flag, 0);
        tick(10'h2C0); chk("R2 h", h_flag, 0); chk("R2 v", v_flag, 0);
        for (int i = 0; i < 4; i++) begin
            tick(10'h155);
            chk("R2 h", h_flag, 0);
            chk("R2 v", v_flag, 0);
        end

        // R6: carrier loss in blanking with V set
        h_mode = 1'b0;
        send_line(1'b1, 0, -1, "");
        carrier_lost = 1'b1;
        tick(10'h155);
        chk("R6 not yet muted dout", dout, 10'h280);
        chk("R6 not yet muted h", h_flag, 1);
        chk("R6 not yet muted v", v_flag, 1);
        tick(10'h155);
        chk("R6 muted dout", dout, 0);
        chk("R6 muted h", h_flag, 0);
        chk("R6 muted v", v_flag, 0);
        chk("R6 muted locked", locked, 0);
        for (int i = 0; i < 3; i++) begin
            tick(10'h3FF);
            chk("R6 muted dout", dout, 0);
        end
        carrier_lost = 1'b0;
        tick(10'h155);
        chk("R6 still muted dout", dout, 0);
        tick(10'h155);
        chk("R6 restored dout", dout, 10'h3FF);
        tick(10'h155);
        chk("R6 restored dout", dout, 10'h3FF);
        send_line(1'b1, 0, 0, "R8 after carrier");
        send_line(1'b1, 0, 0, "R8 after carrier");
        send_line(1'b1, 0, 1, "R8 relock after carrier");
        tick(10'h155);
        chk("R5 v after relock", v_flag, 1);

        // R9: reset mid-stream
        rst = 1'b1;
        tick(10'h3FF);
        chk("R9 dout", dout, 0);
        chk("R9 h", h_flag, 0);
        chk("R9 v", v_flag, 0);
        chk("R9 locked", locked, 0);
        @(negedge clk);
        rst = 1'b0;
        tick(10'h155);
        chk("R9 pipeline cleared", dout, 0);

        finish_run();
    end

endmodule